// File: doc/BRIEF.md
# Descriptor Table Base Register Unit

This unit holds the two descriptor-table registers of a processor core: one for the global table and one for the interrupt table. Each has a 16-bit limit and a 32-bit base. It runs four operations: save either register to memory, or fill either register from memory. A 6-byte pseudo-descriptor moves over a byte-addressed 32-bit memory port. The limit sits at the operand address and the base starts two bytes above it.

The unit enforces the mode rules. A register operand is refused. A table load at a nonzero privilege level in protected mode is refused. A 16-bit load keeps only 24 bits of base. An optional legacy-generation build makes every save write ones into the top byte of the base. Address generation is done elsewhere. The unit takes a finished byte address and reports each result as a single `done` pulse. The pulse carries an exception code when the operation is refused.

Top module: `dtr_unit`

## Requirements
- R1: After reset both tables hold base 0x00000000 and limit 0x03FF, and `done`, `busy` and `mem_req` are low.
- R2: `op_kind` bit 1 set means load and clear means store; bit 0 set selects the interrupt table and clear selects the global table. Memory accesses are issued one at a time. Each access keeps `mem_req`, `mem_addr` and `mem_be` steady until `mem_ack`. Data is right-justified on the 32-bit lanes, with `mem_be` 0011 for a word, 1111 for a dword and 0001 for a byte.
- R3: A store writes the limit as a word at the operand address, then all 32 base bits as a dword at address+2, whatever the operand size.
- R4: With the legacy-fill parameter set, a store writes base bits 31:24 as ones, and the remaining bits come from the register.
- R5: A load with 32-bit operand size reads a word at the address, then a dword at address+2, and takes all 32 base bits.
- R6: A global-table load with 16-bit operand size reads a word at the address, a word at address+2 and a byte at address+4. The base becomes {0x00, byte, word}.
- R7: An interrupt-table load with 16-bit operand size reads a word and then a dword at address+2, and keeps only base bits 23:0. The top byte becomes zero.
- R8: With `op_is_reg` set, every operation ends with `exc_code` 1 (undefined opcode). It makes no memory access and changes no table.
- R9: A load with `prot_mode` high and `cpl` nonzero ends with `exc_code` 2 (general protection, error value 0). This takes precedence over R8 and makes no access. Stores ignore `cpl`, and loads outside protected mode ignore `cpl`.
- R10: `done` is a one-cycle pulse. It comes one cycle after the last acknowledged access, or one cycle after acceptance for a refused operation. A loaded table shows its new value when `done` is high, and `op_valid` is ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation (taken when idle) |
| op_kind | input | 2 | Bit 1 load/store, bit 0 table select |
| op_is_reg | input | 1 | Operand is a register, not memory |
| op_wide | input | 1 | 32-bit operand size |
| prot_mode | input | 1 | Protected mode active |
| cpl | input | 2 | Current privilege level |
| op_addr | input | ADDR_W | Byte address of the pseudo-descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | 4 | Byte enables, right-justified |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| exc_code | output | 2 | 0 none, 1 undefined opcode, 2 general protection; valid with done |
| gdt_limit | output | 16 | Global table limit |
| gdt_base | output | 32 | Global table base |
| idt_limit | output | 16 | Interrupt table limit |
| idt_base | output | 32 | Interrupt table base |

## Verification
When memory acknowledges at once, a refused operation pulses `done` on the first cycle after acceptance. A two-access operation pulses it on the third cycle, and a three-access narrow global load pulses it on the fourth. The bench counts falling edges from the accepting edge and compares that count with the access count plus one. Table outputs and `exc_code` are sampled at that same falling edge. When acknowledgement is withheld, the bench confirms that the request stays steady, and it extends the expected count by the held cycles.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int unsigned LIMIT_W = 16;
  localparam int unsigned BASE_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned NUM_TBL = 2;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_UD   = 2'd1,
    EXC_GP   = 2'd2
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_FINISH = 2'd2
  } state_e;

  // Byte offset of access number 'step' inside the pseudo-descriptor.
  function automatic logic [2:0] step_offset(input logic [1:0] step);
    return {step, 1'b0};
  endfunction

  // Byte enables of access number 'step'.
  function automatic logic [BE_W-1:0] step_be(input logic narrow_gdt,
                                              input logic [1:0] step);
    case (step)
      2'd0:    return 4'b0011;
      2'd1:    return narrow_gdt ? 4'b0011 : 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  // Base image sent to memory on a save.
  function automatic logic [BASE_W-1:0] store_base(input logic [BASE_W-1:0] base,
                                                   input logic fill);
    return fill ? {8'hFF, base[23:0]} : base;
  endfunction

  // Base assembled on the last read of a load.
  function automatic logic [BASE_W-1:0] load_base(input logic narrow_gdt,
                                                  input logic wide,
                                                  input logic [DATA_W-1:0] rdata,
                                                  input logic [15:0] low16);
    if (narrow_gdt)
      return {8'h00, rdata[7:0], low16};
    else if (wide)
      return rdata;
    else
      return {8'h00, rdata[23:0]};
  endfunction
endpackage

// File: rtl/dtr_guard.sv
module dtr_guard
  import dtr_pkg::*;
(
  input  logic       is_load,
  input  logic       is_reg,
  input  logic       prot_mode,
  input  logic [1:0] cpl,
  output exc_e       exc
);
  logic priv_fault;

  assign priv_fault = is_load && prot_mode && (cpl != 2'd0);

  always_comb begin
    if (priv_fault)
      exc = EXC_GP;
    else if (is_reg)
      exc = EXC_UD;
    else
      exc = EXC_NONE;
  end
endmodule

// File: rtl/dtr_regfile.sv
module dtr_regfile
  import dtr_pkg::*;
#(
  parameter logic [LIMIT_W-1:0] RESET_LIMIT = 16'h03FF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_idx,
  input  logic [LIMIT_W-1:0]              wr_limit,
  input  logic [BASE_W-1:0]               wr_base,
  output logic [NUM_TBL-1:0][LIMIT_W-1:0] rd_limit,
  output logic [NUM_TBL-1:0][BASE_W-1:0]  rd_base
);
  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic hit;
    assign hit = wr_en && (wr_idx == 1'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_limit[g] <= RESET_LIMIT;
        rd_base[g]  <= '0;
      end else if (hit) begin
        rd_limit[g] <= wr_limit;
        rd_base[g]  <= wr_base;
      end
    end
  end
endmodule

// File: rtl/dtr_ctrl.sv
module dtr_ctrl
  import dtr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter bit          LEGACY_FILL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic               op_wide,
  input  logic [ADDR_W-1:0]  op_addr,
  input  exc_e               exc_in,
  output logic               tbl_idx,
  input  logic [LIMIT_W-1:0] sel_limit,
  input  logic [BASE_W-1:0]  sel_base,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BE_W-1:0]    mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               commit_we,
  output logic [LIMIT_W-1:0] commit_limit,
  output logic [BASE_W-1:0]  commit_base,
  output logic               busy,
  output logic               done,
  output exc_e               exc_code
);
  state_e             state;
  logic [1:0]         step;
  logic               lat_load, lat_idt, lat_wide;
  logic [ADDR_W-1:0]  lat_addr;
  exc_e               lat_exc;
  logic [LIMIT_W-1:0] tmp_limit;
  logic [15:0]        tmp_low16;

  // Named internal events for the checks below.
  logic       narrow_gdt;
  logic [1:0] last_step;
  logic       xfer_fire;
  logic       xfer_last;

  assign narrow_gdt = lat_load && !lat_idt && !lat_wide;
  assign last_step  = narrow_gdt ? 2'd2 : 2'd1;
  assign xfer_fire  = mem_req && mem_ack;
  assign xfer_last  = xfer_fire && (step == last_step);

  assign tbl_idx   = lat_idt;
  assign mem_req   = (state == ST_XFER);
  assign mem_we    = !lat_load;
  assign mem_addr  = lat_addr + ADDR_W'(step_offset(step));
  assign mem_be    = step_be(narrow_gdt, step);
  assign mem_wdata = (step == 2'd0) ? {{(DATA_W-LIMIT_W){1'b0}}, sel_limit}
                                    : store_base(sel_base, LEGACY_FILL);

  assign commit_we    = xfer_last && lat_load;
  assign commit_limit = tmp_limit;
  assign commit_base  = load_base(narrow_gdt, lat_wide, mem_rdata, tmp_low16);

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);
  assign exc_code = done ? lat_exc : EXC_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step      <= '0;
      lat_load  <= 1'b0;
      lat_idt   <= 1'b0;
      lat_wide  <= 1'b0;
      lat_addr  <= '0;
      lat_exc   <= EXC_NONE;
      tmp_limit <= '0;
      tmp_low16 <= '0;
    end else begin
      case (state)
        ST_IDLE: if (op_valid) begin
          lat_load <= op_kind[1];
          lat_idt  <= op_kind[0];
          lat_wide <= op_wide;
          lat_addr <= op_addr;
          lat_exc  <= exc_in;
          step     <= '0;
          state    <= (exc_in == EXC_NONE) ? ST_XFER : ST_FINISH;
        end
        ST_XFER: if (xfer_fire) begin
          if (step == 2'd0) tmp_limit <= mem_rdata[LIMIT_W-1:0];
          if (step == 2'd1) tmp_low16 <= mem_rdata[15:0];
          step <= step + 2'd1;
          if (xfer_last) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));
  assert_be_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111));
  assert_exc_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code != EXC_NONE) |-> !$past(mem_req));
  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc_code == EXC_NONE) |-> $past(mem_ack));
endmodule

// File: rtl/dtr_unit.sv
module dtr_unit
  import dtr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter bit          LEGACY_FILL = 1'b0,
  parameter logic [15:0] RESET_LIMIT = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_is_reg,
  input  logic              op_wide,
  input  logic              prot_mode,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        exc_code,
  output logic [15:0]       gdt_limit,
  output logic [31:0]       gdt_base,
  output logic [15:0]       idt_limit,
  output logic [31:0]       idt_base
);
  exc_e                            guard_exc;
  exc_e                            ctrl_exc;
  logic                            tbl_idx;
  logic                            commit_we;
  logic [LIMIT_W-1:0]              commit_limit;
  logic [BASE_W-1:0]               commit_base;
  logic [NUM_TBL-1:0][LIMIT_W-1:0] tbl_limit;
  logic [NUM_TBL-1:0][BASE_W-1:0]  tbl_base;

  dtr_guard u_guard (
    .is_load   (op_kind[1]),
    .is_reg    (op_is_reg),
    .prot_mode (prot_mode),
    .cpl       (cpl),
    .exc       (guard_exc)
  );

  dtr_ctrl #(
    .ADDR_W      (ADDR_W),
    .LEGACY_FILL (LEGACY_FILL)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .op_wide      (op_wide),
    .op_addr      (op_addr),
    .exc_in       (guard_exc),
    .tbl_idx      (tbl_idx),
    .sel_limit    (tbl_limit[tbl_idx]),
    .sel_base     (tbl_base[tbl_idx]),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .commit_we    (commit_we),
    .commit_limit (commit_limit),
    .commit_base  (commit_base),
    .busy         (busy),
    .done         (done),
    .exc_code     (ctrl_exc)
  );

  dtr_regfile #(
    .RESET_LIMIT (RESET_LIMIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_we),
    .wr_idx   (tbl_idx),
    .wr_limit (commit_limit),
    .wr_base  (commit_base),
    .rd_limit (tbl_limit),
    .rd_base  (tbl_base)
  );

  assign exc_code  = ctrl_exc;
  assign gdt_limit = tbl_limit[0];
  assign gdt_base  = tbl_base[0];
  assign idt_limit = tbl_limit[1];
  assign idt_base  = tbl_base[1];

  assert_gdt_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(gdt_base) && $stable(gdt_limit)) |-> done);
  assert_idt_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(idt_base) && $stable(idt_limit)) |-> done);
  assert_reg_nomem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_is_reg) |=> !mem_req);
  assert_gp_nomem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_kind[1] && prot_mode && cpl != 2'd0) |=> (done && exc_code == 2'd2));
endmodule

// File: tb/test_dtr_unit.sv
module test_dtr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        op_is_reg = 1'b0;
  logic        op_wide = 1'b0;
  logic        prot_mode = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [31:0] op_addr = '0;
  logic        ack_gate = 1'b1;

  logic        mem_req, mem_we, mem_ack, busy, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [1:0]  exc_code;
  logic [15:0] gdt_limit, idt_limit;
  logic [31:0] gdt_base, idt_base;

  logic        leg_req, leg_we, leg_ack, leg_busy, leg_done;
  logic [31:0] leg_addr, leg_wdata, leg_rdata;
  logic [3:0]  leg_be;
  logic [1:0]  leg_exc;
  logic [15:0] leg_gl, leg_il;
  logic [31:0] leg_gb, leg_ib;
  logic [31:0] leg_wd = '0;

  logic [7:0]  mem [0:63];
  logic [31:0] log_addr [0:15];
  logic [3:0]  log_be [0:15];
  logic        log_we [0:15];
  int          log_n = 0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return {mem[(a+3) & 63], mem[(a+2) & 63], mem[(a+1) & 63], mem[a & 63]};
  endfunction

  assign mem_ack   = mem_req && ack_gate;
  assign mem_rdata = rd_word(mem_addr);
  assign leg_ack   = leg_req && ack_gate;
  assign leg_rdata = rd_word(leg_addr);

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (log_n < 16) begin
        log_addr[log_n] <= mem_addr;
        log_be[log_n]   <= mem_be;
        log_we[log_n]   <= mem_we;
      end
      log_n <= log_n + 1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[(mem_addr + 32'(k)) & 63] <= mem_wdata[8*k +: 8];
      end
    end
    if (leg_req && leg_ack && leg_we && leg_be == 4'hF) leg_wd <= leg_wdata;
  end

  dtr_unit i_dtr_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_is_reg(op_is_reg), .op_wide(op_wide), .prot_mode(prot_mode), .cpl(cpl),
    .op_addr(op_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .exc_code(exc_code), .gdt_limit(gdt_limit),
    .gdt_base(gdt_base), .idt_limit(idt_limit), .idt_base(idt_base));

  dtr_unit #(.LEGACY_FILL(1'b1)) i_dtr_unit_legacy (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_is_reg(op_is_reg), .op_wide(op_wide), .prot_mode(prot_mode), .cpl(cpl),
    .op_addr(op_addr), .mem_req(leg_req), .mem_we(leg_we), .mem_addr(leg_addr),
    .mem_be(leg_be), .mem_wdata(leg_wdata), .mem_ack(leg_ack), .mem_rdata(leg_rdata),
    .busy(leg_busy), .done(leg_done), .exc_code(leg_exc), .gdt_limit(leg_gl),
    .gdt_base(leg_gb), .idt_limit(leg_il), .idt_base(leg_ib));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_bytes(input int a, input logic [7:0] b0, b1, b2, b3, b4, b5);
    mem[a] = b0; mem[a+1] = b1; mem[a+2] = b2;
    mem[a+3] = b3; mem[a+4] = b4; mem[a+5] = b5;
  endtask

  // Issue one operation; returns falling edges from acceptance to done.
  task automatic run_op(input logic [1:0] kind, input logic isreg, input logic wide,
                        input logic pm, input logic [1:0] lvl, input logic [31:0] a,
                        output int lat, output logic [1:0] exc);
    @(negedge clk);
    op_kind = kind; op_is_reg = isreg; op_wide = wide;
    prot_mode = pm; cpl = lvl; op_addr = a; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    exc = exc_code;
  endtask

  task automatic t_reset;
    chk("R1 gdt_base", gdt_base, 32'h0);
    chk("R1 gdt_limit", {16'h0, gdt_limit}, 32'h03FF);
    chk("R1 idt_base", idt_base, 32'h0);
    chk("R1 idt_limit", {16'h0, idt_limit}, 32'h03FF);
    chk("R1 done/busy/req", {29'h0, done, busy, mem_req}, 32'h0);
  endtask

  task automatic t_gdt_load_wide;
    int lat, n0; logic [1:0] e;
    put_bytes(8, 8'h34, 8'h12, 8'hEF, 8'hBE, 8'hAD, 8'hDE);
    n0 = log_n;
    run_op(2'b10, 1'b0, 1'b1, 1'b1, 2'd0, 32'd8, lat, e);
    chk("R5 latency", 32'(lat), 32'd3);
    chk("R5 exc", {30'h0, e}, 32'd0);
    chk("R5 gdt_limit", {16'h0, gdt_limit}, 32'h1234);
    chk("R5 gdt_base", gdt_base, 32'hDEADBEEF);
    chk("R5 idt untouched", idt_base, 32'h0);
    chk("R5 accesses", 32'(log_n - n0), 32'd2);
    chk("R2 acc0 addr", log_addr[n0], 32'd8);
    chk("R2 acc0 be", {28'h0, log_be[n0]}, 32'h3);
    chk("R2 acc1 addr", log_addr[n0+1], 32'd10);
    chk("R2 acc1 be", {28'h0, log_be[n0+1]}, 32'hF);
    chk("R5 read only", {30'h0, log_we[n0], log_we[n0+1]}, 32'h0);
  endtask

  task automatic t_gdt_load_narrow;
    int lat, n0; logic [1:0] e;
    put_bytes(16, 8'h5A, 8'hA5, 8'h11, 8'h22, 8'h33, 8'h44);
    n0 = log_n;
    run_op(2'b10, 1'b0, 1'b0, 1'b1, 2'd0, 32'd16, lat, e);
    chk("R6 latency", 32'(lat), 32'd4);
    chk("R6 gdt_limit", {16'h0, gdt_limit}, 32'hA55A);
    chk("R6 gdt_base", gdt_base, 32'h00332211);
    chk("R6 accesses", 32'(log_n - n0), 32'd3);
    chk("R6 acc1", {log_addr[n0+1][27:0], log_be[n0+1]}, {28'd18, 4'h3});
    chk("R6 acc2", {log_addr[n0+2][27:0], log_be[n0+2]}, {28'd20, 4'h1});
  endtask

  task automatic t_idt_loads;
    int lat; logic [1:0] e;
    put_bytes(24, 8'h0F, 8'h0F, 8'h01, 8'h02, 8'h03, 8'hFF);
    run_op(2'b11, 1'b0, 1'b0, 1'b0, 2'd3, 32'd24, lat, e);
    chk("R7 latency", 32'(lat), 32'd3);
    chk("R9 real mode ignores cpl", {30'h0, e}, 32'd0);
    chk("R7 idt_base", idt_base, 32'h00030201);
    chk("R7 idt_limit", {16'h0, idt_limit}, 32'h0F0F);
    run_op(2'b11, 1'b0, 1'b1, 1'b1, 2'd0, 32'd24, lat, e);
    chk("R5 idt wide base", idt_base, 32'hFF030201);
  endtask

  task automatic t_stores;
    int lat, n0; logic [1:0] e;
    n0 = log_n;
    run_op(2'b00, 1'b0, 1'b0, 1'b1, 2'd3, 32'd32, lat, e);
    chk("R3 latency", 32'(lat), 32'd3);
    chk("R9 store ignores cpl", {30'h0, e}, 32'd0);
    chk("R3 writes", {30'h0, log_we[n0], log_we[n0+1]}, 32'h3);
    chk("R3 limit bytes", {16'h0, mem[33], mem[32]}, 32'hA55A);
    chk("R3 base bytes", {mem[37], mem[36], mem[35], mem[34]}, 32'h00332211);
    chk("R4 legacy fill", leg_wd, 32'hFF332211);
    run_op(2'b01, 1'b0, 1'b1, 1'b1, 2'd0, 32'd40, lat, e);
    chk("R3 idt base bytes", {mem[45], mem[44], mem[43], mem[42]}, 32'hFF030201);
    chk("R3 idt limit bytes", {16'h0, mem[41], mem[40]}, 32'h0F0F);
    chk("R4 legacy keeps low", leg_wd, 32'hFF030201);
  endtask

  task automatic t_reject;
    int lat, n0; logic [1:0] e;
    n0 = log_n;
    run_op(2'b00, 1'b1, 1'b0, 1'b1, 2'd0, 32'd48, lat, e);
    chk("R8 store reg latency", 32'(lat), 32'd1);
    chk("R8 store reg exc", {30'h0, e}, 32'd1);
    run_op(2'b11, 1'b1, 1'b1, 1'b0, 2'd0, 32'd8, lat, e);
    chk("R8 load reg exc", {30'h0, e}, 32'd1);
    chk("R8 idt untouched", idt_base, 32'hFF030201);
    run_op(2'b10, 1'b1, 1'b1, 1'b1, 2'd3, 32'd8, lat, e);
    chk("R9 gp precedence", {30'h0, e}, 32'd2);
    run_op(2'b10, 1'b0, 1'b1, 1'b1, 2'd1, 32'd8, lat, e);
    chk("R9 gp latency", 32'(lat), 32'd1);
    chk("R9 gp exc", {30'h0, e}, 32'd2);
    chk("R9 gdt untouched", gdt_base, 32'h00332211);
    chk("R8 R9 no accesses", 32'(log_n - n0), 32'd0);
  endtask

  task automatic t_ack_hold;
    int lat, n0; logic [1:0] e;
    n0 = log_n;
    ack_gate = 1'b0;
    @(negedge clk);
    op_kind = 2'b10; op_is_reg = 1'b0; op_wide = 1'b1;
    prot_mode = 1'b1; cpl = 2'd0; op_addr = 32'd8; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_kind = 2'b00;
    repeat (3) @(negedge clk);
    chk("R2 req held", {31'h0, mem_req}, 32'h1);
    chk("R2 addr held", mem_addr, 32'd8);
    op_valid = 1'b0;
    ack_gate = 1'b1;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 done after release", 32'(lat), 32'd2);
    chk("R10 busy op ignored", 32'(log_n - n0), 32'd2);
    chk("R10 loaded at done", gdt_base, 32'hDEADBEEF);
    @(negedge clk);
    chk("R10 done pulse", {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gdt_load_wide;
    t_gdt_load_narrow;
    t_idt_loads;
    t_stores;
    t_reject;
    t_ack_hold;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule